// File: doc/BRIEF.md
# Systolic Ring Neuron Layer

This block evaluates one fully connected neural layer of P inputs and P outputs on a closed ring of P multiply-accumulate elements. Element i holds row i of the weight matrix in a small local store. Once a vector is accepted, every element loads one value and the ring runs for exactly P shift steps. In each step every element multiplies its current value by the weight picked by (own index + step) modulo P and adds the product to a 40-bit accumulator. After the last step, each accumulator is rounded, saturated to 16 bits and, in forward mode, passed through a sigmoid lookup table.

In forward mode the activations move one place around the ring on each step while the partial sums stay in place. In backward mode the roles swap. Each element keeps its own error term, and the partial sums travel around the ring. Every sum then collects one column of the matrix, which gives the transposed product that training needs without a second copy of the weights. Backward results skip the sigmoid.

Vectors enter on a valid/ready stream and results leave on another. A vector is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. The result holds for as long as `out_ready` stays low, and no new vector is accepted until the result has been taken. Weights are written through a plain write port, and only while the ring is idle. All data is signed fixed point with 8 fraction bits. Element j of a vector sits at bits [16j+15:16j].

Top module: `ring_layer`

## Requirements
- R1: During and right after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: In forward mode (`in_mode`=0), output i is the activation of net_i = Σ_j W[i][j]·x[j], where W[i][j] is the word written with `wr_pe`=i and `wr_addr`=j, and x[j] is input element j.
- R3: The forward activation takes k = clamp(net >>> 4, -64, 63) from the rounded, saturated 16-bit net and returns 128 + 4k − (k·|k|)/32, with the division truncated toward zero. The result therefore always lies in [0, 256].
- R4: In backward mode (`in_mode`=1), output j is Σ_i W[i][j]·d[i], with input element i taken as d[i], and no activation is applied.
- R5: Every sum of raw 16×16 products is rounded by adding 128 and shifting right arithmetically by 8. The result is then saturated to the range [−32768, 32767].
- R6: `out_valid` rises on the (P+1)-th rising edge after the edge that accepts a vector.
- R7: From the accepting edge until the result is taken, `in_ready` is 0, `in_valid` has no effect, and `in_ready` and `out_valid` are never high together.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_vec` does not change.
- R9: A weight write takes effect only in a cycle with `in_ready`=1. Writes in other cycles are ignored.
- R10: The accumulators clear at every accepted vector, so each result depends only on the weights and that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight write strobe |
| wr_pe | input | $clog2(P) | Element (matrix row) to write |
| wr_addr | input | $clog2(P) | Column within that row |
| wr_data | input | DW | Signed weight, 8 fraction bits |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Ring idle, vector can be accepted |
| in_mode | input | 1 | 0 forward, 1 backward; sampled with the vector |
| in_vec | input | P*DW | Activations or error terms |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | P*DW | Activations or error sums |

## Verification
The bench builds the ring with P=5. An odd ring whose size is not a power of two makes the weight index wrap modulo P at a different step in each element, and leaves write addresses above P−1 unused. The short pass keeps latency, stall and back-to-back runs cheap to repeat in both directions. An identity matrix turns forward runs into a sweep of the sigmoid table, covering both clamped ends and the steps at ±16. Unit weights with half-step error terms reach the rounding boundary of R5 directly.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic {
    MODE_FWD = 1'b0,
    MODE_BWD = 1'b1
  } ring_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_ACT,
    ST_HOLD
  } ring_state_e;
endpackage

// File: rtl/ring_pe.sv
module ring_pe
  import ring_pkg::*;
#(
  parameter int P    = 10,
  parameter int DW   = 16,
  parameter int ACCW = 40,
  parameter int IDX  = 0,
  localparam int SW  = $clog2(P)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   run,
  input  ring_mode_e             mode,
  input  logic [SW-1:0]          step,
  input  logic signed [DW-1:0]   x_init,
  input  logic signed [DW-1:0]   x_next,
  input  logic signed [ACCW-1:0] sum_next,
  input  logic                   wr_en,
  input  logic [SW-1:0]          wr_addr,
  input  logic signed [DW-1:0]   wr_data,
  output logic signed [DW-1:0]   x_out,
  output logic signed [ACCW-1:0] sum_out,
  output logic signed [ACCW-1:0] acc_out
);
  localparam int PW = 2 * DW;

  logic signed [DW-1:0]   wmem [P];
  logic signed [DW-1:0]   x_q;
  logic signed [ACCW-1:0] acc_q;
  logic [SW:0]            idx_raw;
  logic [SW:0]            idx;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] sum;

  // weight column for this step: (own index + step) mod P
  always_comb begin
    idx_raw = (SW+1)'(IDX) + {1'b0, step};
    idx     = (idx_raw >= (SW+1)'(P)) ? idx_raw - (SW+1)'(P) : idx_raw;
  end

  assign prod = wmem[idx[SW-1:0]] * x_q;
  assign sum  = acc_q + {{(ACCW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < SW'(P))) wmem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      acc_q <= '0;
    end else if (load) begin
      x_q   <= x_init;
      acc_q <= '0;
    end else if (run) begin
      if (mode == MODE_FWD) begin
        x_q   <= x_next;
        acc_q <= sum;
      end else begin
        acc_q <= sum_next;
      end
    end
  end

  assign x_out   = x_q;
  assign sum_out = sum;
  assign acc_out = acc_q;
endmodule

// File: rtl/ring_act.sv
module ring_act
  import ring_pkg::*;
#(
  parameter int DW        = 16,
  parameter int ACCW      = 40,
  parameter int FRAC      = 8,
  parameter int LUT_AW    = 7,
  parameter int LUT_SHIFT = 4
) (
  input  logic signed [ACCW-1:0] acc,
  input  ring_mode_e             mode,
  output logic signed [DW-1:0]   y
);
  localparam int N    = 1 << LUT_AW;
  localparam int HALF = N / 2;
  localparam logic signed [DW-1:0] Q_HI = DW'(HALF - 1);
  localparam logic signed [DW-1:0] Q_LO = DW'(-HALF);
  localparam logic signed [ACCW-1:0] RND = ACCW'(1) <<< (FRAC - 1);

  function automatic logic [DW-1:0] lut_entry(input int k);
    int one, xf, mag;
    one = 1 << FRAC;
    xf  = k * (1 << LUT_SHIFT);
    mag = (xf < 0) ? -xf : xf;
    return DW'(one / 2 + xf / 4 - (xf * mag) / (32 * one));
  endfunction

  logic [DW-1:0] lut [N];
  for (genvar g = 0; g < N; g++) begin : g_lut
    assign lut[g] = lut_entry(g - HALF);
  end

  logic signed [ACCW-1:0] rnd;
  logic signed [ACCW-1:0] sh;
  logic signed [DW-1:0]   net;
  logic signed [DW-1:0]   q;
  logic [LUT_AW-1:0]      idx;

  always_comb begin
    rnd = acc + RND;
    sh  = rnd >>> FRAC;
    if (sh[ACCW-1:DW-1] == '0 || sh[ACCW-1:DW-1] == '1)
      net = sh[DW-1:0];
    else
      net = sh[ACCW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};

    q = net >>> LUT_SHIFT;
    if (q > Q_HI)      idx = '1;
    else if (q < Q_LO) idx = '0;
    else               idx = LUT_AW'(q + DW'(HALF));

    y = (mode == MODE_FWD) ? lut[idx] : net;
  end
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
#(
  parameter int P  = 10,
  localparam int SW = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_mode,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          load,
  output logic          run,
  output logic          act_en,
  output ring_mode_e    mode,
  output logic [SW-1:0] step
);
  ring_state_e state;

  assign in_ready  = (state == ST_IDLE);
  assign load      = in_ready && in_valid;
  assign run       = (state == ST_RUN);
  assign act_en    = (state == ST_ACT);
  assign out_valid = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      mode  <= MODE_FWD;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          step  <= '0;
          mode  <= ring_mode_e'(in_mode);
        end
        ST_RUN: begin
          step <= step + 1'b1;
          if (step == SW'(P - 1)) state <= ST_ACT;
        end
        ST_ACT:  state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_layer.sv
module ring_layer
  import ring_pkg::*;
#(
  parameter int P         = 10,
  parameter int DW        = 16,
  parameter int ACCW      = 40,
  parameter int FRAC      = 8,
  parameter int LUT_AW    = 7,
  parameter int LUT_SHIFT = 4,
  localparam int SW       = $clog2(P)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_pe,
  input  logic [SW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_mode,
  input  logic [P*DW-1:0] in_vec,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P*DW-1:0] out_vec
);
  logic          load, run, act_en;
  ring_mode_e    mode;
  logic [SW-1:0] step;

  logic signed [DW-1:0]   x_bus   [P];
  logic signed [ACCW-1:0] sum_bus [P];
  logic signed [ACCW-1:0] acc_bus [P];
  logic signed [DW-1:0]   act_bus [P];
  logic signed [DW-1:0]   out_q   [P];

  ring_ctrl #(.P(P)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .load(load), .run(run), .act_en(act_en), .mode(mode), .step(step)
  );

  for (genvar g = 0; g < P; g++) begin : g_pe
    localparam int NXT = (g + 1) % P;
    logic pe_wr;
    assign pe_wr = wr_en && in_ready && (wr_pe == SW'(g));

    ring_pe #(.P(P), .DW(DW), .ACCW(ACCW), .IDX(g)) u_pe (
      .clk(clk), .rst_n(rst_n), .load(load), .run(run), .mode(mode),
      .step(step), .x_init(in_vec[g*DW +: DW]), .x_next(x_bus[NXT]),
      .sum_next(sum_bus[NXT]), .wr_en(pe_wr), .wr_addr(wr_addr),
      .wr_data(wr_data), .x_out(x_bus[g]), .sum_out(sum_bus[g]),
      .acc_out(acc_bus[g])
    );

    ring_act #(.DW(DW), .ACCW(ACCW), .FRAC(FRAC), .LUT_AW(LUT_AW),
               .LUT_SHIFT(LUT_SHIFT)) u_act (
      .acc(acc_bus[g]), .mode(mode), .y(act_bus[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q[g] <= '0;
      else if (act_en) out_q[g] <= act_bus[g];
    end

    assign out_vec[g*DW +: DW] = out_q[g];
  end
endmodule

// File: rtl/ring_layer_chk.sv
module ring_layer_chk #(
  parameter int P    = 10,
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_mode,
  input logic            out_valid,
  input logic            out_ready,
  input logic [P*DW-1:0] out_vec
);
  localparam logic signed [DW-1:0] ONE = DW'(1 << FRAC);

  int   cnt;
  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= 0;
      mode_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      cnt    <= 0;
      mode_q <= in_mode;
    end else if (!in_ready && !out_valid) begin
      cnt <= cnt + 1;
    end
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> cnt == P + 1);

  for (genvar g = 0; g < P; g++) begin : g_rng
    assert_fwd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !mode_q |->
        ($signed(out_vec[g*DW +: DW]) >= 0 && $signed(out_vec[g*DW +: DW]) <= ONE));
  end
endmodule

bind ring_layer ring_layer_chk #(.P(P), .DW(DW), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
  .out_vec(out_vec)
);

// File: tb/ring_layer_tb.sv
module ring_layer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 5;
  localparam int DW = 16;
  localparam int SW = $clog2(P);
  typedef logic [P*DW-1:0] vec_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [SW-1:0] wr_pe, wr_addr;
  logic [DW-1:0] wr_data;
  logic          in_valid, in_ready, in_mode;
  vec_t          in_vec;
  logic          out_valid, out_ready;
  vec_t          out_vec;

  ring_layer #(.P(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pe(wr_pe), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_vec(in_vec), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic signed [DW-1:0] W [P][P];
  vec_t exp_q [$];
  vec_t snap;
  bit   stalled = 0;

  task automatic check_int(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec(bit ok, string req, vec_t act, vec_t exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // R5 rounding and saturation
  function automatic longint rnd_sat(longint acc);
    longint r;
    r = (acc + 128) >>> 8;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // R3 activation table rule
  function automatic longint act_fn(longint net);
    int k;
    k = int'(net) >>> 4;
    if (k > 63)  k = 63;
    if (k < -64) k = -64;
    return 128 + 4*k - (k * ((k < 0) ? -k : k)) / 32;
  endfunction

  function automatic vec_t model(bit bwd, vec_t v);
    vec_t r;
    for (int o = 0; o < P; o++) begin
      longint acc = 0;
      longint n;
      for (int t = 0; t < P; t++) begin
        if (!bwd) acc += longint'(W[o][t]) * longint'($signed(v[t*DW +: DW]));
        else      acc += longint'(W[t][o]) * longint'($signed(v[t*DW +: DW]));
      end
      n = rnd_sat(acc);
      r[o*DW +: DW] = bwd ? DW'(n) : DW'(act_fn(n));
    end
    return r;
  endfunction

  task automatic wr_w(int pe, int a, logic [DW-1:0] d, bit track);
    wr_en = 1; wr_pe = SW'(pe); wr_addr = SW'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (track) W[pe][a] = d;
  endtask

  task automatic send(bit m, vec_t v);
    exp_q.push_back(model(m, v));
    in_valid = 1; in_mode = m; in_vec = v;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !in_ready) begin @(posedge clk); #1; end
  endtask

  function automatic vec_t mk(int a0, int a1, int a2, int a3, int a4);
    vec_t r;
    r = {DW'(a4), DW'(a3), DW'(a2), DW'(a1), DW'(a0)};
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (!out_ready) begin
        if (stalled) check_vec(out_vec == snap, "R8 held result", out_vec, snap);
        snap = out_vec;
        stalled = 1;
      end else begin
        stalled = 0;
        if (exp_q.size() == 0) check_vec(0, "R7 unexpected result", out_vec, '0);
        else begin
          vec_t e;
          e = exp_q.pop_front();
          check_vec(out_vec == e, "R2/R3/R4/R5/R10 result", out_vec, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    check_int(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_pe = '0; wr_addr = '0; wr_data = '0;
    in_valid = 0; in_mode = 0; in_vec = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    check_int(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    check_int(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check_int(in_ready == 1 && out_valid == 0, "R1 after reset", {in_ready, out_valid}, 2);

    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        wr_w(i, j, DW'(((i*11 + j*7) % 23 - 11) * 20), 1);

    // R2 forward, R6 latency
    send(0, mk(-320, 120, 280, -40, 200));
    begin
      int n = 0;
      check_int(in_ready == 0, "R7 busy after accept", in_ready, 0);
      do begin @(posedge clk); #1; n++; end while (!out_valid && n < 50);
      check_int(n == P + 1, "R6 latency", n, P + 1);
    end
    wait_idle();

    // R7 in_valid ignored while busy
    send(0, mk(100, -100, 50, 25, -75));
    in_valid = 1; in_vec = mk(7000, 7000, 7000, 7000, 7000);
    for (int c = 0; c < 3; c++) begin
      check_int(in_ready == 0, "R7 in_ready low while busy", in_ready, 0);
      @(posedge clk); #1;
    end
    in_valid = 0;
    wait_idle();

    // R4 backward
    send(1, mk(256, -128, 64, 512, -300));
    wait_idle();

    // R8 back-pressure
    out_ready = 0;
    send(1, mk(-50, 90, 300, -200, 10));
    repeat (P + 6) begin @(posedge clk); #1; end
    check_int(out_valid == 1, "R8 out_valid held", out_valid, 1);
    check_int(in_ready == 0, "R7 no accept while holding", in_ready, 0);
    out_ready = 1;
    wait_idle();

    // R9 write while busy ignored, R10 back-to-back clear
    send(0, mk(200, 200, -200, 100, 0));
    wr_w(0, 0, 16'h7fff, 0);
    wr_w(2, 3, 16'h8000, 0);
    send(0, mk(200, 200, -200, 100, 0));
    send(1, mk(200, 200, -200, 100, 0));
    wait_idle();

    // R3 table sweep through identity weights
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        wr_w(i, j, (i == j) ? 16'd256 : 16'd0, 1);
    send(0, mk(-32768, -1025, -1024, -17, -16));
    send(0, mk(-1, 0, 15, 16, 1007));
    send(0, mk(1008, 1023, 1024, 32767, 500));
    wait_idle();

    // R5 rounding at half step with unit weights
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        wr_w(i, j, 16'd1, 1);
    send(1, mk(128, 0, 0, 0, 0));
    send(1, mk(-128, 0, 0, 0, 0));
    send(1, mk(-129, 0, 0, 0, 0));
    send(1, mk(127, 0, 0, 0, 0));
    wait_idle();

    // R5 saturation both ways
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        wr_w(i, j, 16'h7fff, 1);
    send(1, mk(32767, 32767, 32767, 32767, 32767));
    send(1, mk(-32768, -32768, -32768, -32768, -32768));
    send(0, mk(32767, 32767, 32767, 32767, 32767));
    send(0, mk(-32768, 0, 0, 0, 0));
    wait_idle();

    check_int(exp_q.size() == 0, "R7 all results drained", exp_q.size(), 0);
    finish_run();
  end
endmodule